// File: doc/BRIEF.md
# Slave Sync Field and Standard Detector

This block follows an external pair of active-low sync strobes, horizontal and vertical, that come from an upstream video source. It registers both on the pixel clock and runs a pixel counter and a line counter locked to their falling edges. It also measures the clock count of each line and uses that measurement as the ruler for the field decision.

When a vertical falling edge arrives, the block looks at where it landed inside the current line. An edge near the line start opens the first field of a frame, and an edge near the line midpoint opens the second. An edge in neither place is flagged as an error. The number of lines seen between vertical edges decides between the 525-line and the 625-line standard. The flag only moves after two fields in a row agree.

A downstream encoder uses the counters, the field bit, the standard flag and the lock indicator to place its own timing events. With default parameters it expects a clock at twice the luminance sample rate: 1716 clocks per 525-line line and 1728 per 625-line line.

Top module: `syncSlaveDetect`

## Requirements
- R1: Both sync inputs are sampled on the rising clock edge. Take edge k as the first edge that samples `hsyncN` low after it was sampled high. `pixCount` then reads 1 after edge k+1, rises by one on every later edge, and saturates at 2^PIX_W-1.
- R2: At that same edge k+1, `lineCount` rises by one, saturating at 2^LINE_W-1. It otherwise holds.
- R3: Take edge v as the first edge that samples `vsyncN` low after it was sampled high. `lineCount` reads 1 after edge v+1, and this takes priority over R2 in the same cycle.
- R4: Let p be the value of `pixCount` after edge v, and L the stored length of the last complete line. p equals L when both syncs fall at the same edge. If p < L/4 or p > L-L/4, with integer division, `fieldTwo` is 0 after edge v+1.
- R5: If R4 does not apply and L/2-L/4 < p < L/2+L/4, `fieldTwo` is 1 after edge v+1.
- R6: A vertical edge that meets neither R4 nor R5, or that arrives before a complete line length has been stored, sets `fieldErr` after edge v+1 and leaves `fieldTwo` unchanged. A vertical edge that meets R4 or R5 clears `fieldErr`.
- R7: At each vertical edge after the first one since reset, the vote is 625 lines (1) if `lineCount` after edge v exceeds LINE_SPLIT, and 525 lines (0) otherwise. `pal625` takes the vote after edge v+1 only when the vote equals the previous vote. It changes at no other time.
- R8: At each horizontal edge after the first one, the line length is `pixCount` after edge k. It is judged good if it lies within LEN_TOL of CLK_625 when `pal625` is 1, or of CLK_525 when `pal625` is 0. `locked` is 1 when the most recent judgement is good and the most recent vertical edge met R4 or R5.
- R9: After reset, `pixCount`, `lineCount`, `fieldTwo`, `fieldErr`, `pal625` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hsyncN | input | 1 | Horizontal sync, active low |
| vsyncN | input | 1 | Vertical sync, active low |
| pixCount | output | PIX_W | Clocks since the current line began, starting at 1 |
| lineCount | output | LINE_W | Lines since the current field began, starting at 1 |
| fieldTwo | output | 1 | 0 for the first field of a frame, 1 for the second |
| fieldErr | output | 1 | The last vertical edge fell outside both windows |
| pal625 | output | 1 | 1 for 625-line operation, 0 for 525-line |
| locked | output | 1 | Line length in tolerance and field placement valid |

## Verification
The bench places vertical edges exactly on the quarter-line and three-quarter-line boundaries. A design with inclusive window compares would report a field there instead of an error. It also makes both syncs fall on the same edge, where a design that forgets that the stored length is still one line old would pick the wrong window, and where a design that lets the horizontal increment win would leave the line count at its old value plus one. It moves through 525-line and 625-line fields to catch a standard flag that switches on a single field. Finally, it sends lines that are one and two clocks off nominal and one line long enough to saturate the pixel counter, so an off-by-one tolerance or a wrapping counter would show up in `locked` or `pixCount`.

// File: rtl/syncDetPkg.sv
package syncDetPkg;

  // strobes handed from the control to the counter datapath
  typedef struct packed {
    logic lineStart;   // horizontal falling edge seen this cycle
    logic fieldStart;  // vertical falling edge seen this cycle
  } syncStrobeT;

endpackage

// File: rtl/syncEdge.sv
module syncEdge (
  input  logic clk,
  input  logic rstN,
  input  logic syncN,
  output logic fallStb
);

  logic stage1;
  logic stage2;

  // idle level of an active-low sync is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b1;
      stage2 <= 1'b1;
    end else begin
      stage1 <= syncN;
      stage2 <= stage1;
    end
  end

  assign fallStb = stage2 & ~stage1;

endmodule

// File: rtl/syncCount.sv
module syncCount
  import syncDetPkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncStrobeT        strb,
  output logic [PIX_W-1:0]  pixCount,
  output logic [PIX_W-1:0]  lineLen,
  output logic [LINE_W-1:0] lineCount,
  output logic              lineSeen,
  output logic              lenValid
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount <= '0;
    end else if (strb.lineStart) begin
      pixCount <= PIX_W'(1);
    end else if (pixCount != PIX_MAX) begin
      pixCount <= pixCount + PIX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCount <= '0;
    end else if (strb.fieldStart) begin
      lineCount <= LINE_W'(1);
    end else if (strb.lineStart && lineCount != LINE_MAX) begin
      lineCount <= lineCount + LINE_W'(1);
    end
  end

  // the first edge after reset only starts the ruler; the second yields a length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSeen <= 1'b0;
      lenValid <= 1'b0;
      lineLen  <= '0;
    end else if (strb.lineStart) begin
      lineSeen <= 1'b1;
      if (lineSeen) begin
        lineLen  <= pixCount;
        lenValid <= 1'b1;
      end
    end
  end

  p_pix_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineStart |=> pixCount == PIX_W'(1));

  p_pix_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lineStart && pixCount != PIX_MAX) |=> pixCount == $past(pixCount) + PIX_W'(1));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineStart && !strb.fieldStart && lineCount != LINE_MAX)
      |=> lineCount == $past(lineCount) + LINE_W'(1));

  p_line_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fieldStart |=> lineCount == LINE_W'(1));

endmodule

// File: rtl/syncCtrl.sv
module syncCtrl
  import syncDetPkg::*;
#(
  parameter int PIX_W      = 11,
  parameter int LINE_W     = 10,
  parameter int CLK_525    = 1716,
  parameter int CLK_625    = 1728,
  parameter int LEN_TOL    = 2,
  parameter int LINE_SPLIT = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              vsyncN,
  input  logic [PIX_W-1:0]  pixCount,
  input  logic [PIX_W-1:0]  lineLen,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              lineSeen,
  input  logic              lenValid,
  output syncStrobeT        strb,
  output logic              fieldTwo,
  output logic              fieldErr,
  output logic              pal625,
  output logic              locked
);

  localparam int EXT_W   = PIX_W + 1;
  localparam int N_SYNCS = 2;

  logic [N_SYNCS-1:0] syncIn;
  logic [N_SYNCS-1:0] fallVec;

  assign syncIn = {vsyncN, hsyncN};

  genvar g;
  generate
    for (g = 0; g < N_SYNCS; g++) begin : gEdge
      syncEdge uEdge (
        .clk    (clk),
        .rstN   (rstN),
        .syncN  (syncIn[g]),
        .fallStb(fallVec[g])
      );
    end
  endgenerate

  logic hsFall, vsFall;
  assign hsFall = fallVec[0];
  assign vsFall = fallVec[1];

  always_comb begin
    strb.lineStart  = hsFall;
    strb.fieldStart = vsFall;
  end

  // window arithmetic, one bit wider so sums cannot wrap
  logic [EXT_W-1:0] phase, lenExt, quarter, half;
  logic inStart, inMid, goodF1, goodF2;

  always_comb begin
    phase   = {1'b0, pixCount};
    lenExt  = {1'b0, lineLen};
    quarter = lenExt >> 2;
    half    = lenExt >> 1;
    inStart = (phase < quarter) || (phase > lenExt - quarter);
    inMid   = (phase + quarter > half) && (phase < half + quarter);
    goodF1  = lenValid && inStart;
    goodF2  = lenValid && inMid && !inStart;
  end

  // line length check against the nominal for the standard in force
  logic [EXT_W-1:0] nomLen, lenDiff;
  logic lenInTol, vote;

  always_comb begin
    nomLen   = pal625 ? EXT_W'(CLK_625) : EXT_W'(CLK_525);
    lenDiff  = (phase >= nomLen) ? (phase - nomLen) : (nomLen - phase);
    lenInTol = lineSeen && (lenDiff <= EXT_W'(LEN_TOL));
    vote     = lineCount > LINE_W'(LINE_SPLIT);
  end

  logic fieldGood, lenOk, vsSeen, lastVote, voteValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldTwo  <= 1'b0;
      fieldErr  <= 1'b0;
      fieldGood <= 1'b0;
    end else if (vsFall) begin
      if (goodF1) begin
        fieldTwo  <= 1'b0;
        fieldErr  <= 1'b0;
        fieldGood <= 1'b1;
      end else if (goodF2) begin
        fieldTwo  <= 1'b1;
        fieldErr  <= 1'b0;
        fieldGood <= 1'b1;
      end else begin
        fieldErr  <= 1'b1;
        fieldGood <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pal625    <= 1'b0;
      vsSeen    <= 1'b0;
      lastVote  <= 1'b0;
      voteValid <= 1'b0;
    end else if (vsFall) begin
      vsSeen <= 1'b1;
      if (vsSeen) begin
        lastVote  <= vote;
        voteValid <= 1'b1;
        if (voteValid && vote == lastVote) pal625 <= vote;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lenOk <= 1'b0;
    else if (hsFall) lenOk <= lenInTol;
  end

  assign locked = lenOk && fieldGood;

  p_pal_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !vsFall |=> $stable(pal625));

  p_field_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vsFall && !goodF1 && !goodF2) |=> $stable(fieldTwo) && fieldErr);

  p_field_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !vsFall |=> $stable(fieldTwo) && $stable(fieldErr));

  p_lock_field_r8: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !fieldErr);

endmodule

// File: rtl/syncSlaveDetect.sv
module syncSlaveDetect
  import syncDetPkg::*;
#(
  parameter int PIX_W      = 11,
  parameter int LINE_W     = 10,
  parameter int CLK_525    = 1716,
  parameter int CLK_625    = 1728,
  parameter int LEN_TOL    = 2,
  parameter int LINE_SPLIT = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              vsyncN,
  output logic [PIX_W-1:0]  pixCount,
  output logic [LINE_W-1:0] lineCount,
  output logic              fieldTwo,
  output logic              fieldErr,
  output logic              pal625,
  output logic              locked
);

  syncStrobeT       strb;
  logic [PIX_W-1:0] lineLen;
  logic             lineSeen, lenValid;

  syncCtrl #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .CLK_525(CLK_525), .CLK_625(CLK_625),
    .LEN_TOL(LEN_TOL), .LINE_SPLIT(LINE_SPLIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .pixCount(pixCount), .lineLen(lineLen), .lineCount(lineCount),
    .lineSeen(lineSeen), .lenValid(lenValid), .strb(strb),
    .fieldTwo(fieldTwo), .fieldErr(fieldErr), .pal625(pal625), .locked(locked)
  );

  syncCount #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uCount (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pixCount(pixCount), .lineLen(lineLen), .lineCount(lineCount),
    .lineSeen(lineSeen), .lenValid(lenValid)
  );

endmodule

// File: tb/sim_syncSlaveDetect.sv
module sim_syncSlaveDetect;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8, LW = 6, C525 = 40, C625 = 48, TOL = 1, SPLIT = 12;
  localparam int HS_W = 4, VS_W = 6;
  localparam int PMAX = (1 << PW) - 1, LMAX = (1 << LW) - 1;

  logic clk = 1'b0, rstN = 1'b0, hsyncN = 1'b1, vsyncN = 1'b1;
  logic [PW-1:0] pixCount;
  logic [LW-1:0] lineCount;
  logic fieldTwo, fieldErr, pal625, locked;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncSlaveDetect #(.PIX_W(PW), .LINE_W(LW), .CLK_525(C525), .CLK_625(C625),
                    .LEN_TOL(TOL), .LINE_SPLIT(SPLIT)) u0 (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .pixCount(pixCount), .lineCount(lineCount), .fieldTwo(fieldTwo),
    .fieldErr(fieldErr), .pal625(pal625), .locked(locked));

  int tests = 0, fails = 0;
  int lineIdx = 0, prevLen = 0, prevPrevLen = 0, expLine = 0;
  bit expTwo = 0, expErr = 0, expGood = 0, expPal = 0;
  bit vsSeenB = 0, lastVote = 0, voteValid = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // 0 = first field, 1 = second field, 2 = outside both windows (R4, R5, R6)
  function automatic int classify(input int len, input int p);
    int q = len / 4;
    int h = len / 2;
    if (p < q || p > len - q) return 0;
    if (p > h - q && p < h + q) return 1;
    return 2;
  endfunction

  // one line; off < 0 means no vertical edge in it
  task automatic runLine(input int len, input int off);
    int lineAfterHs, cnt, p, ruler, cls, nom;
    bit vote, lenOkNew;
    nom = expPal ? C625 : C525;
    lenOkNew = (lineIdx >= 1) && (absDiff(prevLen, nom) <= TOL);
    lineAfterHs = (expLine < LMAX) ? expLine + 1 : LMAX;
    cls = 0;
    if (off >= 0) begin
      cnt   = (off == 0) ? expLine : lineAfterHs;
      p     = (off == 0) ? prevLen : off;
      ruler = (off == 0) ? prevPrevLen : prevLen;
      cls   = (lineIdx >= 2) ? classify(ruler, p) : 2;
      if (cls == 2) begin expErr = 1; expGood = 0; end
      else begin expTwo = (cls == 1); expErr = 0; expGood = 1; end
      vote = cnt > SPLIT;
      if (vsSeenB) begin
        if (voteValid && vote == lastVote) expPal = vote;
        lastVote = vote;
        voteValid = 1;
      end
      vsSeenB = 1;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 2) begin
        chk("R1 pixel restart", pixCount, 1);
        if (off != 0) chk("R2 line step", lineCount, lineAfterHs);
      end
      if (off >= 0 && i == off + 2) begin
        chk("R3 line restart", lineCount, 1);
        chk(cls == 1 ? "R5 field id" : "R4 field id", fieldTwo, expTwo);
        chk("R6 field error", fieldErr, expErr);
        chk("R7 standard flag", pal625, expPal);
      end
      if (i == len - 1) begin
        chk("R1 pixel run", pixCount, (len - 2 < PMAX) ? len - 2 : PMAX);
        chk("R8 lock", locked, lenOkNew && expGood);
      end
      hsyncN = (i < HS_W) ? 1'b0 : 1'b1;
      vsyncN = (off >= 0 && i >= off && i < off + VS_W) ? 1'b0 : 1'b1;
    end
    expLine = (off >= 0) ? 1 : lineAfterHs;
    prevPrevLen = prevLen;
    prevLen = len;
    lineIdx++;
  endtask

  task automatic runField(input int len, input int nLines, input int off);
    for (int ln = 0; ln < nLines; ln++) runLine(len, (ln == 0) ? off : -1);
  endtask

  initial begin
    int len;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset pixCount", pixCount, 0);
    chk("R9 reset lineCount", lineCount, 0);
    chk("R9 reset fieldTwo", fieldTwo, 0);
    chk("R9 reset fieldErr", fieldErr, 0);
    chk("R9 reset pal625", pal625, 0);
    chk("R9 reset locked", locked, 0);
    rstN = 1'b1;

    runLine(40, -1);
    runLine(40, -1);

    // random 525-line fields, lengths within tolerance, random edge placement
    for (int f = 0; f < 8; f++) begin
      len = 39 + $urandom_range(0, 2);
      runField(len, 10 + $urandom_range(0, 1), $urandom_range(0, len - 7));
    end

    // directed window boundaries (R4, R5, R6)
    runLine(40, -1);
    runLine(40, -1);
    runField(40, 3, 10);
    runField(40, 3, 30);
    runField(40, 3, 9);
    runField(40, 3, 11);
    runField(40, 3, 29);
    runField(40, 3, 0);
    runField(40, 3, 31);

    // R8 tolerance edges
    runLine(42, -1);
    runLine(40, -1);
    runLine(41, -1);
    runLine(40, -1);
    runLine(39, -1);
    runLine(40, -1);

    // R7 switch to 625 lines and back
    for (int f = 0; f < 4; f++) runField(48, 14 + $urandom_range(0, 1), $urandom_range(0, 41));
    for (int f = 0; f < 4; f++) runField(40, 10, $urandom_range(0, 33));

    // R1 saturation on an over-long line, then recovery
    runLine(300, -1);
    runLine(40, -1);
    runLine(40, -1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule